// File: doc/BRIEF.md
# SAR Converter Sequencer with Sleep-Aware Control

This block runs a 10-bit successive-approximation conversion for a core that programs it through two byte-wide control registers. Software picks a conversion clock, an input channel and a result alignment, then sets the go bit. The sequencer drives a trial code to an external DAC and reads back a single comparator bit, which is modelled here as a digital input. It builds the result one bit per conversion-clock period, starting with the MSB. When the result is complete, the sequencer loads it into a 16-bit result register, clears go and raises an interrupt flag.

The block also reacts to three system events. The first is sleep entry. With the internal RC clock selected, a conversion carries on through sleep and can wake the core. With any divided system clock, sleep kills the conversion and powers the converter down, and the enable bit stays set. The second is device reset, which clears the control state and returns every pin to analog mode, but leaves the result register untouched. The third is a special-event trigger from a compare unit. It starts a conversion when the converter is enabled, and it always asks for the timer to be cleared.

All pins are plain control and status signals. The result is held in a register and has no handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Reset (rst_n low) forces both control registers to read 0x00. It clears go, the flag, wake_req and tmr_clr_req, and sets pin_cfg to 0 (all analog). It does not change result.
- R2: Control register 0 (wr_addr=0) holds clock select in bits 7:6, channel in bits 5:3, go in bit 2 and enable in bit 0. Bit 1 always reads 0, and chan_sel follows bits 5:3. Control register 1 (wr_addr=1) holds the format bit in bit 7 and pin_cfg in bits 3:0.
- R3: With clock select s in {0,1,2}, a period is DIV_BASE*4^s clocks. The go bit reads 0 exactly 11 periods after the clock edge that accepts the start, and result then equals the code that the comparator bit selects at each trial (a bit is kept when cmp_in is 1).
- R4: go clears, result loads and adc_flag sets on the same clock edge. adc_flag stays set until flag_clr is pulsed.
- R5: When the format bit is 1, the 10-bit code sits in result bits 9:0 and bits 15:10 are zero. When the format bit is 0, the code sits in bits 15:6 and bits 5:0 are zero.
- R6: A write that sets go while writing enable as 0 starts nothing, and go reads 0.
- R7: A write that clears go (or enable) while a conversion runs aborts the conversion. result is unchanged and adc_flag stays 0.
- R8: With clock select 3 (RC), trials begin INSTR_CLKS clocks after the start, and each trial advances only on an rc_tick pulse. With rc_tick held high, go reads 0 exactly INSTR_CLKS+11 clocks after the start.
- R9: With sleep_in high, enable set and clock select not 3, the next edge aborts any conversion and drives conv_active to 0. Enable still reads 1. conv_active returns to 1 on the edge after sleep_in falls.
- R10: With clock select 3, a conversion completes during sleep. If int_en is 1, wake_req pulses for one cycle on the completion edge. If int_en is 0, conv_active drops to 0 and enable still reads 1.
- R11: A trig_in pulse while trig_mode is 4'b1011 and enable is 1 sets go on the next edge and pulses tmr_clr_req for one cycle.
- R12: The same trigger while enable is 0 leaves go at 0 but still pulses tmr_clr_req. When trig_mode is any other value, the trigger does neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| wr_data | input | 8 | Write data |
| ctl0_rd | output | 8 | Control register 0 readback, with go live |
| ctl1_rd | output | 8 | Control register 1 readback |
| result | output | OUT_W | Aligned conversion result |
| chan_sel | output | 3 | Selected input channel |
| pin_cfg | output | 4 | Pin mode field, 0 means all analog |
| dac_code | output | RES_W | Trial code for the external DAC |
| cmp_in | input | 1 | Comparator result: input at or above dac_code |
| rc_tick | input | 1 | One-clock pulse per internal RC period |
| sleep_in | input | 1 | Core is asleep |
| int_en | input | 1 | Converter interrupt enable |
| flag_clr | input | 1 | Clears adc_flag |
| adc_flag | output | 1 | Conversion-complete interrupt flag |
| wake_req | output | 1 | Wake-up request pulse |
| conv_active | output | 1 | Converter powered (enabled and not powered down) |
| trig_mode | input | 4 | Compare-unit mode field |
| trig_in | input | 1 | Compare-unit special-event pulse |
| tmr_clr_req | output | 1 | Timer clear request pulse |

## Verification
The bench builds the block with its defaults: RES_W=10, OUT_W=16, DIV_BASE=2 and INSTR_CLKS=4. The slowest divided clock is then 32 clocks per period, so a full conversion takes 352 cycles, and many random conversions fit in one run. Because the result register is wider than the code by six bits, both alignments produce visibly different words. A short RC start delay means that the exact latency in RC mode (15 clocks when rc_tick is held high) and a stalled-rc_tick case can both be checked directly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_CONV} seq_st_e;

  localparam logic [1:0] CS_RC     = 2'b11;
  localparam logic [3:0] TRIG_MODE = 4'b1011;

  localparam int C0_EN  = 0;
  localparam int C0_GO  = 2;
  localparam int C0_CHL = 3;
  localparam int C0_CSL = 6;
  localparam int C1_FMT = 7;
endpackage

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
  parameter int DIV_BASE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] cs,
  input  logic       rc_tick,
  output logic       tick
);
  import adc_seq_pkg::*;

  localparam int DIV_MAX = DIV_BASE * 16;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_m1;
  logic             div_hit;

  always_comb begin
    case (cs)
      2'b00:   div_m1 = CNT_W'(DIV_BASE - 1);
      2'b01:   div_m1 = CNT_W'(DIV_BASE * 4 - 1);
      default: div_m1 = CNT_W'(DIV_MAX - 1);
    endcase
  end

  assign div_hit = (cnt_q == div_m1);
  assign tick    = run & ((cs == CS_RC) ? rc_tick : div_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!run || cs == CS_RC)   cnt_q <= '0;
    else if (div_hit)               cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV_BASE > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cs != CS_RC) |=> !tick) else $error("tick gap");  // R3
    end
  endgenerate
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] sar_val,
  output logic             done
);
  localparam int STEP_W = $clog2(RES_W + 1);

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  sar_q;
  logic [RES_W-1:0]  trial;

  genvar gi;
  generate
    for (gi = 0; gi < RES_W; gi++) begin : g_bit
      assign trial[gi] = (step_q == STEP_W'(RES_W - 1 - gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sar_q[gi] <= 1'b0;
        else if (!run)              sar_q[gi] <= 1'b0;
        else if (tick && trial[gi]) sar_q[gi] <= cmp_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   step_q <= '0;
    else if (!run)                                step_q <= '0;
    else if (tick && step_q != STEP_W'(RES_W))    step_q <= step_q + 1'b1;
  end

  assign dac_code = sar_q | trial;
  assign sar_val  = sar_q;
  assign done     = run & tick & (step_q == STEP_W'(RES_W));

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(RES_W)) else $error("step range");  // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sar_q == '0)) else $error("sar not cleared");  // R3
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W      = 10,
  parameter int OUT_W      = 16,
  parameter int DIV_BASE   = 2,
  parameter int INSTR_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctl0_rd,
  output logic [7:0]       ctl1_rd,
  output logic [OUT_W-1:0] result,
  output logic [2:0]       chan_sel,
  output logic [3:0]       pin_cfg,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in,
  input  logic             rc_tick,
  input  logic             sleep_in,
  input  logic             int_en,
  input  logic             flag_clr,
  output logic             adc_flag,
  output logic             wake_req,
  output logic             conv_active,
  input  logic [3:0]       trig_mode,
  input  logic             trig_in,
  output logic             tmr_clr_req
);
  import adc_seq_pkg::*;

  localparam int DLY_W = (INSTR_CLKS > 1) ? $clog2(INSTR_CLKS) : 1;

  seq_st_e          st_q;
  logic [DLY_W-1:0] dly_q;
  logic [1:0]       cs_q;
  logic [2:0]       ch_q;
  logic             en_q, go_q, fmt_q, pdn_q;
  logic [3:0]       pcfg_q;
  logic             flag_q, wake_q, tmr_q;
  logic [OUT_W-1:0] res_q;

  logic wr0, wr1, trig_hit, sleep_kill, sw_start, hw_start, start, abort;
  logic [1:0] cs_eff;
  logic run, tick, done;
  logic [RES_W-1:0] sar_val;
  logic [OUT_W-1:0] res_right, res_left;

  assign wr0        = wr_en & ~wr_addr;
  assign wr1        = wr_en &  wr_addr;
  assign cs_eff     = wr0 ? wr_data[C0_CSL +: 2] : cs_q;
  assign trig_hit   = trig_in & (trig_mode == TRIG_MODE);
  assign sleep_kill = sleep_in & en_q & (cs_q != CS_RC);
  assign sw_start   = wr0 & wr_data[C0_GO] & wr_data[C0_EN];
  assign hw_start   = trig_hit & en_q & ~(wr0 & ~wr_data[C0_EN]);
  assign start      = (sw_start | hw_start) & ~go_q &
                      ~(sleep_in & (cs_eff != CS_RC));
  assign abort      = go_q & wr0 & (~wr_data[C0_GO] | ~wr_data[C0_EN]);
  assign run        = (st_q == ST_CONV);

  adc_conv_clk #(.DIV_BASE(DIV_BASE)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .cs(cs_q),
    .rc_tick(rc_tick), .tick(tick)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cmp_in(cmp_in),
    .dac_code(dac_code), .sar_val(sar_val), .done(done)
  );

  generate
    if (OUT_W > RES_W) begin : g_pad
      assign res_right = {{(OUT_W-RES_W){1'b0}}, sar_val};
      assign res_left  = {sar_val, {(OUT_W-RES_W){1'b0}}};
    end else begin : g_nopad
      assign res_right = OUT_W'(sar_val);
      assign res_left  = OUT_W'(sar_val);
    end
  endgenerate

  // Control register fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0; ch_q <= '0; en_q <= 1'b0; fmt_q <= 1'b0; pcfg_q <= '0;
    end else begin
      if (wr0) begin
        cs_q <= wr_data[C0_CSL +: 2];
        ch_q <= wr_data[C0_CHL +: 3];
        en_q <= wr_data[C0_EN];
      end
      if (wr1) begin
        fmt_q  <= wr_data[C1_FMT];
        pcfg_q <= wr_data[3:0];
      end
    end
  end

  // Sequencing: sleep kill beats software abort beats completion beats start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; go_q <= 1'b0; dly_q <= '0;
    end else if (sleep_kill || abort || done) begin
      st_q <= ST_IDLE; go_q <= 1'b0;
    end else if (start) begin
      go_q  <= 1'b1;
      dly_q <= '0;
      st_q  <= (cs_eff == CS_RC) ? ST_DELAY : ST_CONV;
    end else if (st_q == ST_DELAY) begin
      if (dly_q == DLY_W'(INSTR_CLKS - 1)) st_q <= ST_CONV;
      else                                 dly_q <= dly_q + 1'b1;
    end
  end

  // Power-down, flag, wake and timer request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q <= 1'b0; flag_q <= 1'b0; wake_q <= 1'b0; tmr_q <= 1'b0;
    end else begin
      if (!sleep_in)                              pdn_q <= 1'b0;
      else if (sleep_kill || (done && !int_en))   pdn_q <= 1'b1;
      if (done)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      wake_q <= done & sleep_in & int_en;
      tmr_q  <= trig_hit;
    end
  end

  // Result holds its contents across reset
  always_ff @(posedge clk) begin
    if (done) res_q <= fmt_q ? res_right : res_left;
  end

  assign ctl0_rd     = {cs_q, ch_q, go_q, 1'b0, en_q};
  assign ctl1_rd     = {fmt_q, 3'b000, pcfg_q};
  assign result      = res_q;
  assign chan_sel    = ch_q;
  assign pin_cfg     = pcfg_q;
  assign adc_flag    = flag_q;
  assign wake_req    = wake_q;
  assign conv_active = en_q & ~pdn_q;
  assign tmr_clr_req = tmr_q;

  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> en_q) else $error("go without enable");  // R6
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (adc_flag && !go_q)) else $error("done handling");  // R4
  AST_SLEEP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_kill |=> (!go_q && !conv_active)) else $error("sleep kill");  // R9
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req) else $error("wake width");  // R10
  AST_TRIG_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> tmr_clr_req) else $error("timer request");  // R11
  AST_TRIG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && trig_mode != TRIG_MODE) |=> !tmr_clr_req) else $error("trig mode");  // R12
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PER    = 10;
  localparam int RES_W      = 10;
  localparam int OUT_W      = 16;
  localparam int DIV_BASE   = 2;
  localparam int INSTR_CLKS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctl0_rd, ctl1_rd;
  logic [OUT_W-1:0] result;
  logic [2:0] chan_sel;
  logic [3:0] pin_cfg;
  logic [RES_W-1:0] dac_code;
  logic cmp_in;
  logic rc_tick = 1'b0, sleep_in = 1'b0, int_en = 1'b0, flag_clr = 1'b0;
  logic adc_flag, wake_req, conv_active;
  logic [3:0] trig_mode = '0;
  logic trig_in = 1'b0;
  logic tmr_clr_req;
  logic [RES_W-1:0] ana_val = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;
  assign cmp_in = (ana_val >= dac_code);

  adc_seq_ctrl #(.RES_W(RES_W), .OUT_W(OUT_W), .DIV_BASE(DIV_BASE),
                 .INSTR_CLKS(INSTR_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl0_rd(ctl0_rd), .ctl1_rd(ctl1_rd),
    .result(result), .chan_sel(chan_sel), .pin_cfg(pin_cfg),
    .dac_code(dac_code), .cmp_in(cmp_in), .rc_tick(rc_tick),
    .sleep_in(sleep_in), .int_en(int_en), .flag_clr(flag_clr),
    .adc_flag(adc_flag), .wake_req(wake_req), .conv_active(conv_active),
    .trig_mode(trig_mode), .trig_in(trig_in), .tmr_clr_req(tmr_clr_req)
  );

  function automatic logic [OUT_W-1:0] exp_fmt(input logic [RES_W-1:0] v, input bit right);
    logic [OUT_W-1:0] w;
    w = OUT_W'(v);
    return right ? w : (w << (OUT_W - RES_W));
  endfunction

  function automatic int exp_cycles(input int cs);
    return 11 * DIV_BASE * (4 ** cs);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (ctl0_rd[2] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, seed;
    logic [OUT_W-1:0] held;
    seed = $urandom(32'h1d5e);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctl0", ctl0_rd, 8'h00);
    chk("R1 ctl1", ctl1_rd, 8'h00);
    chk("R1 flag", adc_flag, 0);
    chk("R1 tmr", tmr_clr_req, 0);
    chk("R1 wake", wake_req, 0);
    rst_n = 1'b1;

    // R2 layout
    wr(1'b0, 8'hEB);
    chk("R2 ctl0 readback", ctl0_rd, 8'hE9);
    chk("R2 chan_sel", chan_sel, 5);
    wr(1'b1, 8'hFA);
    chk("R2 ctl1 readback", ctl1_rd, 8'h8A);
    chk("R2 pin_cfg", pin_cfg, 4'hA);

    // R6 go with enable 0
    wr(1'b0, 8'h2C);
    chk("R6 go ignored", ctl0_rd, 8'h28);
    repeat (40) @(negedge clk);
    chk("R6 no flag", adc_flag, 0);

    // R3 R4 R5 random conversions
    for (int i = 0; i < 24; i++) begin
      int cs;
      bit right;
      cs = $urandom % 3;
      right = $urandom % 2;
      ana_val = RES_W'($urandom);
      if (i == 0) ana_val = '0;
      if (i == 1) ana_val = '1;
      wr(1'b1, {right, 7'b0});
      wr(1'b0, {2'(cs), 3'(i), 1'b1, 1'b0, 1'b1});
      wait_go(n);
      chk("R3 latency", n, exp_cycles(cs));
      chk("R5 result alignment", result, exp_fmt(ana_val, right));
      chk("R4 flag with done", adc_flag, 1);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk("R4 flag cleared", adc_flag, 0);
    end

    // R7 software abort
    held = result;
    ana_val = 10'h155;
    wr(1'b0, 8'h85);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h81);
    repeat (400) @(negedge clk);
    chk("R7 go cleared", ctl0_rd[2], 0);
    chk("R7 result kept", result, held);
    chk("R7 no flag", adc_flag, 0);

    // R1 reset mid-conversion keeps result
    wr(1'b0, 8'h85);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ctl0 after reset", ctl0_rd, 8'h00);
    chk("R1 pin_cfg analog", pin_cfg, 0);
    chk("R1 result kept", result, held);
    rst_n = 1'b1;

    // R8 RC delay and rc_tick pacing
    wr(1'b1, 8'h80);
    ana_val = 10'h2C7;
    rc_tick = 1'b1;
    wr(1'b0, 8'hC5);
    wait_go(n);
    chk("R8 RC latency", n, INSTR_CLKS + 11);
    chk("R8 RC result", result, exp_fmt(10'h2C7, 1));
    rc_tick = 1'b0;
    wr(1'b0, 8'hC5);
    repeat (100) @(negedge clk);
    chk("R8 stalled without rc_tick", ctl0_rd[2], 1);
    rc_tick = 1'b1;
    wait_go(n);
    chk("R8 resumes", result, exp_fmt(10'h2C7, 1));

    // R9 sleep with divided clock
    held = result;
    wr(1'b0, 8'h45);
    repeat (6) @(negedge clk);
    sleep_in = 1'b1;
    @(negedge clk);
    chk("R9 aborted", ctl0_rd[2], 0);
    chk("R9 powered down", conv_active, 0);
    chk("R9 enable kept", ctl0_rd[0], 1);
    repeat (400) @(negedge clk);
    chk("R9 result kept", result, held);
    sleep_in = 1'b0;
    @(negedge clk);
    chk("R9 power back", conv_active, 1);

    // R10 RC through sleep, interrupt enabled
    ana_val = 10'h0F3;
    int_en = 1'b1;
    wr(1'b0, 8'hC5);
    sleep_in = 1'b1;
    wait_go(n);
    chk("R10 wake pulse", wake_req, 1);
    chk("R10 result in sleep", result, exp_fmt(10'h0F3, 1));
    @(negedge clk);
    chk("R10 wake one cycle", wake_req, 0);
    chk("R10 still powered", conv_active, 1);
    sleep_in = 1'b0;
    int_en = 1'b0;
    // R10 interrupt disabled
    wr(1'b0, 8'hC5);
    sleep_in = 1'b1;
    wait_go(n);
    chk("R10 no wake", wake_req, 0);
    chk("R10 power down", conv_active, 0);
    chk("R10 enable kept", ctl0_rd[0], 1);
    sleep_in = 1'b0;
    @(negedge clk);

    // R11 trigger while enabled
    ana_val = 10'h3A1;
    wr(1'b0, 8'h01);
    trig_mode = 4'b1011;
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    chk("R11 go set", ctl0_rd[2], 1);
    chk("R11 timer request", tmr_clr_req, 1);
    @(negedge clk);
    chk("R11 request one cycle", tmr_clr_req, 0);
    wait_go(n);
    chk("R11 triggered result", result, exp_fmt(10'h3A1, 1));

    // R12 trigger while disabled, and wrong mode
    wr(1'b0, 8'h00);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    chk("R12 no start", ctl0_rd[2], 0);
    chk("R12 timer still cleared", tmr_clr_req, 1);
    wr(1'b0, 8'h01);
    trig_mode = 4'b1010;
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    chk("R12 wrong mode no start", ctl0_rd[2], 0);
    chk("R12 wrong mode no request", tmr_clr_req, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule